// File: doc/BRIEF.md
# Queued SPI Master Engine

This block is an SPI master that executes a list of up to sixteen transfers prepared in advance by a host, with no host involvement between transfers. The host loads a per-entry command byte and a 16-bit transmit word into local storage, gives a first and a last entry index, and pulses a start input. The engine then walks the entries in order. For each entry it drives the chip-select lines, generates the serial clock and shifts the word out while shifting a word in. The received word lands in the receive slot with the same index.

When the last entry has finished, a completion flag rises and, if enabled, an interrupt line follows it. The host clears the flag by pulsing a clear input. A chip-select line may stay asserted from one entry into the next, under control of a bit in the command byte. An external slave-select sense input that goes low while the engine is running is treated as a bus conflict. It aborts the queue, stops the engine and sets a sticky fault flag.

Command byte layout: bits [3:0] form the chip-select mask, where a 1 drives that chip-select line low during the entry. Bit 7 is the hold bit. Bits 6:4 are ignored. The queue depth must be a power of two, so that index arithmetic wraps naturally.

Top module: `spiq_master`

## Requirements
- R1: After a start pulse, entries run from `start_ptr` through `end_ptr` inclusive, stepping +1 and wrapping from 15 to 0 when `end_ptr` is below `start_ptr`. `cur_idx` shows the index of the entry being transferred, and exactly ((end-start) mod 16)+1 transfers occur.
- R2: Each entry sends its transmit word MSB first on `mosi` and captures 16 bits from `miso`. The captured word is written to the receive slot with the same index, and `rx_rdata` returns slot `rx_addr` one clock after the address is applied.
- R3: While an entry transfers, `cs_n` equals the bitwise inverse of command bits [3:0]. While the engine is idle, `cs_n` is all ones.
- R4: If command bit 7 is 1 and the entry is not the last one, `cs_n` does not return to all ones before the next entry. If bit 7 is 0, or the entry is the last one, `cs_n` returns to all ones after the entry.
- R5: `sck` rests at `cpol` when no transfer runs. Each `sck` half period lasts `clk_half` clocks. With `cpha`=0, `miso` is sampled on the leading (away-from-idle) edge. With `cpha`=1, it is sampled on the trailing edge.
- R6: `done_flag` rises in the same clock edge at which `busy` falls after the last entry. A `done_clr` pulse clears it. If completion and `done_clr` fall in the same cycle, the flag is set.
- R7: `irq` is a registered copy of `done_flag` gated by `irq_en`, and it falls when the flag is cleared.
- R8: If `ss_in_n` is low while `busy` is high, the queue stops at the next edge. `busy` goes low, `cs_n` goes all ones, `fault_flag` is set and `done_flag` is not set. While `fault_flag` is set, start pulses are ignored. `fault_clr` clears `fault_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe into command/transmit storage |
| host_sel | input | 1 | 0 selects the command byte, 1 selects the transmit word |
| host_addr | input | 4 | Entry index for the host write |
| host_wdata | input | 16 | Write data (command uses bits 7 and 3:0) |
| rx_addr | input | 4 | Receive slot index to read |
| rx_rdata | output | 16 | Receive slot contents, one clock after `rx_addr` |
| start_ptr | input | 4 | First entry to run |
| end_ptr | input | 4 | Last entry to run |
| go | input | 1 | Start pulse |
| clk_half | input | 8 | System clocks per `sck` half period (0 treated as 1) |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Sampling edge select |
| irq_en | input | 1 | Interrupt enable |
| done_clr | input | 1 | Clears the completion flag |
| fault_clr | input | 1 | Clears the fault flag |
| miso | input | 1 | Serial data in |
| ss_in_n | input | 1 | Slave-select sense, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 4 | Chip selects, active low |
| busy | output | 1 | Queue is running |
| done_flag | output | 1 | Queue completion flag |
| fault_flag | output | 1 | Sticky bus-conflict flag |
| irq | output | 1 | Interrupt request |
| cur_idx | output | 4 | Index of the running entry |

## Verification
The completion flag has two writers: the sequencer sets it when the last entry finishes, and the host clears it with `done_clr`. These two can fall in the same cycle. The bench provokes this by holding `done_clr` high across a whole queue run, so the clear is present in exactly the cycle where completion fires. It then expects the flag high in the first sample after `busy` falls and low one clock later. A behavioural slave model reconstructs each transferred word in every clock mode and rebuilds the expected entry order, chip-select patterns and chip-select release count arithmetically from the pointers and command bytes.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_START, S_XFER} seq_st_t;
endpackage

// File: rtl/spiq_ram.sv
// Command, transmit and receive storage; synchronous reads for block RAM.
module spiq_ram #(
  parameter int DEPTH    = 16,
  parameter int AW       = 4,
  parameter int DW       = 16,
  parameter int CSW      = 4,
  parameter int HOLD_BIT = 7
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [CSW:0]  eng_cmd,
  output logic [DW-1:0] eng_tx,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [DW-1:0] eng_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [DW-1:0] host_rdata
);
  logic [CSW:0]  cmd_mem [DEPTH];
  logic [DW-1:0] tx_mem  [DEPTH];
  logic [DW-1:0] rx_mem  [DEPTH];

  // only the host port writes command storage
  always_ff @(posedge clk) begin
    if (host_we && !host_sel)
      cmd_mem[host_addr] <= {host_wdata[HOLD_BIT], host_wdata[CSW-1:0]};
    eng_cmd <= cmd_mem[eng_raddr];
  end

  always_ff @(posedge clk) begin
    if (host_we && host_sel) tx_mem[host_addr] <= host_wdata;
    eng_tx <= tx_mem[eng_raddr];
  end

  always_ff @(posedge clk) begin
    if (eng_we) rx_mem[eng_waddr] <= eng_wdata;
    host_rdata <= rx_mem[host_raddr];
  end
endmodule

// File: rtl/spiq_shift.sv
// Serial clock generator and MSB-first shifter for one word.
module spiq_shift #(
  parameter int DW   = 16,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            abort,
  input  logic [DW-1:0]   tx_word,
  input  logic [DIVW-1:0] clk_half,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            done,
  output logic            active,
  output logic [DW-1:0]   rx_word
);
  localparam int EW = $clog2(2*DW) + 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(2*DW);

  logic [DW-1:0]   sreg;
  logic [DIVW-1:0] div_cnt;
  logic [EW-1:0]   edge_n, k;
  logic            tick, lead, do_sample, do_shift;

  always_comb begin
    tick      = ({1'b0, div_cnt} + (DIVW+1)'(1)) >= {1'b0, clk_half};
    k         = edge_n + EW'(1);
    lead      = k[0];
    do_sample = cpha ? !lead : lead;
    do_shift  = cpha ? (lead && k != EW'(1)) : (!lead && k != LAST_EDGE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      done    <= 1'b0;
      sck     <= 1'b0;
      sreg    <= '0;
      rx_word <= '0;
      div_cnt <= '0;
      edge_n  <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sck    <= cpol;
      end else if (start) begin
        active  <= 1'b1;
        sreg    <= tx_word;
        div_cnt <= '0;
        edge_n  <= '0;
        sck     <= cpol;
      end else if (active) begin
        if (tick) begin
          div_cnt <= '0;
          edge_n  <= k;
          sck     <= ~sck;
          if (do_sample) rx_word <= {rx_word[DW-2:0], miso};
          if (do_shift)  sreg    <= {sreg[DW-2:0], 1'b0};
          if (k == LAST_EDGE) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + DIVW'(1);
        end
      end else begin
        sck <= cpol;
      end
    end
  end

  assign mosi = sreg[DW-1];

  // R5: outside a transfer the clock settles to the idle level
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !active |=> sck == $past(cpol));
  // R2: a word completes only out of a running transfer
  p_done_from_active_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(active));
endmodule

// File: rtl/spiq_seq.sv
// Queue walker: pointer, chip selects, completion and fault flags.
module spiq_seq
  import spiq_pkg::*;
#(
  parameter int AW  = 4,
  parameter int CSW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [AW-1:0]  start_ptr,
  input  logic [AW-1:0]  end_ptr,
  input  logic           done_clr,
  input  logic           fault_clr,
  input  logic           irq_en,
  input  logic           ss_in_n,
  input  logic [CSW:0]   cmd,
  input  logic           sh_done,
  output logic [AW-1:0]  ptr,
  output logic           sh_start,
  output logic           sh_abort,
  output logic           rx_we,
  output logic [CSW-1:0] cs_n,
  output logic           busy,
  output logic           done_flag,
  output logic           fault_flag,
  output logic           irq
);
  seq_st_t       state;
  logic [AW-1:0] endp;
  logic          hold_q, mf, fin, done_next;

  always_comb begin
    mf        = (state != S_IDLE) && !ss_in_n;
    fin       = (state == S_XFER) && sh_done && (ptr == endp) && !mf;
    done_next = fin || (done_flag && !done_clr);
    sh_start  = (state == S_START) && !mf;
    sh_abort  = mf;
    rx_we     = (state == S_XFER) && sh_done && !mf;
    busy      = (state != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ptr        <= '0;
      endp       <= '0;
      hold_q     <= 1'b0;
      cs_n       <= '1;
      done_flag  <= 1'b0;
      fault_flag <= 1'b0;
      irq        <= 1'b0;
    end else begin
      done_flag  <= done_next;
      irq        <= irq_en && done_next;
      fault_flag <= mf || (fault_flag && !fault_clr);
      case (state)
        S_IDLE: if (go && !fault_flag) begin
          ptr   <= start_ptr;
          endp  <= end_ptr;
          state <= S_FETCH;
        end
        S_FETCH: state <= S_START;
        S_START: begin
          cs_n   <= ~cmd[CSW-1:0];
          hold_q <= cmd[CSW];
          state  <= S_XFER;
        end
        S_XFER: if (sh_done) begin
          if (ptr == endp) begin
            cs_n  <= '1;
            state <= S_IDLE;
          end else begin
            if (!hold_q) cs_n <= '1;
            ptr   <= ptr + AW'(1);
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (mf) begin
        state <= S_IDLE;
        cs_n  <= '1;
      end
    end
  end

  // R1: moving to a new entry advances the index by one, modulo depth
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH && $past(state) == S_XFER) |-> ptr == $past(ptr) + AW'(1));
  // R3: no chip select is driven while idle
  p_cs_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> cs_n == '1);
  // R6: completion is only ever reported with the engine stopped
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> state == S_IDLE);
  // R7: interrupt never stands without the completion flag
  p_irq_done_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_flag);
  // R8: a pending fault keeps the engine from starting
  p_fault_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    fault_flag |=> state == S_IDLE);
endmodule

// File: rtl/spiq_master.sv
module spiq_master #(
  parameter int DEPTH    = 16,
  parameter int DW       = 16,
  parameter int CSW      = 4,
  parameter int DIVW     = 8,
  parameter int HOLD_BIT = 7,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_we,
  input  logic            host_sel,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  input  logic [AW-1:0]   rx_addr,
  output logic [DW-1:0]   rx_rdata,
  input  logic [AW-1:0]   start_ptr,
  input  logic [AW-1:0]   end_ptr,
  input  logic            go,
  input  logic [DIVW-1:0] clk_half,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            irq_en,
  input  logic            done_clr,
  input  logic            fault_clr,
  input  logic            miso,
  input  logic            ss_in_n,
  output logic            sck,
  output logic            mosi,
  output logic [CSW-1:0]  cs_n,
  output logic            busy,
  output logic            done_flag,
  output logic            fault_flag,
  output logic            irq,
  output logic [AW-1:0]   cur_idx
);
  logic [CSW:0]  eng_cmd;
  logic [DW-1:0] eng_tx, sh_rx;
  logic          sh_start, sh_abort, sh_done, sh_active, rx_we;

  spiq_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CSW(CSW), .HOLD_BIT(HOLD_BIT)) u_ram (
    .clk(clk), .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
    .host_wdata(host_wdata), .eng_raddr(cur_idx), .eng_cmd(eng_cmd), .eng_tx(eng_tx),
    .eng_we(rx_we), .eng_waddr(cur_idx), .eng_wdata(sh_rx),
    .host_raddr(rx_addr), .host_rdata(rx_rdata));

  spiq_shift #(.DW(DW), .DIVW(DIVW)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .abort(sh_abort), .tx_word(eng_tx),
    .clk_half(clk_half), .cpol(cpol), .cpha(cpha), .miso(miso), .sck(sck),
    .mosi(mosi), .done(sh_done), .active(sh_active), .rx_word(sh_rx));

  spiq_seq #(.AW(AW), .CSW(CSW)) u_seq (
    .clk(clk), .rst(rst), .go(go), .start_ptr(start_ptr), .end_ptr(end_ptr),
    .done_clr(done_clr), .fault_clr(fault_clr), .irq_en(irq_en), .ss_in_n(ss_in_n),
    .cmd(eng_cmd), .sh_done(sh_done), .ptr(cur_idx), .sh_start(sh_start),
    .sh_abort(sh_abort), .rx_we(rx_we), .cs_n(cs_n), .busy(busy),
    .done_flag(done_flag), .fault_flag(fault_flag), .irq(irq));

  // R3: the shifter only clocks data while a chip-select pattern is out
  p_active_busy_r3: assert property (@(posedge clk) disable iff (rst)
    sh_active |-> busy);
endmodule

// File: tb/test_spiq_master.sv
module test_spiq_master;
  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 0, host_sel = 0, go = 0, cpol = 0, cpha = 0, irq_en = 0;
  logic done_clr = 0, fault_clr = 0, ss_in_n = 1, miso;
  logic [3:0] host_addr = 0, rx_addr = 0, start_ptr = 0, end_ptr = 0, cur_idx;
  logic [15:0] host_wdata = 0, rx_rdata;
  logic [7:0] clk_half = 8'd1;
  logic sck, mosi, busy, done_flag, fault_flag, irq;
  logic [3:0] cs_n;

  always #5 clk = ~clk;

  spiq_master i_spiq_master (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
    .host_wdata(host_wdata), .rx_addr(rx_addr), .rx_rdata(rx_rdata),
    .start_ptr(start_ptr), .end_ptr(end_ptr), .go(go), .clk_half(clk_half),
    .cpol(cpol), .cpha(cpha), .irq_en(irq_en), .done_clr(done_clr),
    .fault_clr(fault_clr), .miso(miso), .ss_in_n(ss_in_n), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .busy(busy), .done_flag(done_flag), .fault_flag(fault_flag),
    .irq(irq), .cur_idx(cur_idx));

  int n_tests = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] tx_of(input int idx, input int run);
    return 16'((idx * 16'h1111) ^ (run * 16'h0F35) ^ 16'h8421);
  endfunction
  function automatic bit hold_of(input int idx, input int run);
    return ((idx + run) % 3) == 0;
  endfunction
  function automatic logic [3:0] mask_of(input int idx, input int run);
    return 4'(((idx * 5 + run) % 15) + 1);
  endfunction
  function automatic logic [15:0] resp(input int n);
    return 16'((n * 16'h1357) ^ 16'hC0DE);
  endfunction

  // behavioural slave: samples on the edge the mode dictates
  int s_n = 0, s_bi = 0;
  logic [15:0] s_in = 0, cur_resp;
  logic [15:0] cap [64];
  logic [3:0] cslog [64];
  logic [3:0] idxlog [64];
  always_comb cur_resp = resp(s_n);
  assign miso = cur_resp[4'(15 - s_bi)];

  always @(sck) begin
    if (cs_n != 4'hF && s_n < 64) begin
      if ((sck != cpol) != cpha) begin
        s_in = {s_in[14:0], mosi};
        s_bi = s_bi + 1;
        if (s_bi == 16) begin
          cap[s_n] = s_in; cslog[s_n] = cs_n; idxlog[s_n] = cur_idx;
          s_bi = 0; s_n = s_n + 1;
        end
      end
    end
  end

  // chip-select releases and sck half-period monitor
  logic [3:0] cs_prev = 4'hF;
  logic sck_prev = 0;
  int rel_cnt = 0, gap_bad = 0, edge_in = 0, last_edge = 0;
  always @(negedge clk) begin
    if (cs_prev != 4'hF && cs_n == 4'hF) rel_cnt++;
    cs_prev = cs_n;
    if (sck != sck_prev && cs_n != 4'hF) begin
      if (edge_in > 0 && (cyc - last_edge) != int'(clk_half)) gap_bad++;
      last_edge = cyc;
      edge_in = (edge_in == 31) ? 0 : edge_in + 1;
    end
    sck_prev = sck;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic host_wr(input bit sel, input int a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1; host_sel = sel; host_addr = 4'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic load_queue(input int run);
    for (int i = 0; i < 16; i++) begin
      host_wr(0, i, {8'h0, hold_of(i, run), 3'b101, mask_of(i, run)});
      host_wr(1, i, tx_of(i, run));
    end
  endtask

  task automatic run_q(input int st, input int en, input int m, input int h,
                       input bit ien, input int run, input bit clr_hold);
    int len, exp_rel, idx;
    load_queue(run);
    @(negedge clk);
    cpol = m[1]; cpha = m[0]; clk_half = 8'(h); irq_en = ien;
    start_ptr = 4'(st); end_ptr = 4'(en);
    s_n = 0; s_bi = 0; rel_cnt = 0; gap_bad = 0; edge_in = 0;
    done_clr = clr_hold;
    go = 1;
    @(negedge clk);
    go = 0;
    chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    while (busy) @(negedge clk);
    chk(done_flag == 1'b1, "R6", "done when busy falls", int'(done_flag), 1);
    chk(irq == ien, "R7", "irq follows enable", int'(irq), int'(ien));
    chk(cs_n == 4'hF, "R4", "cs released at end", int'(cs_n), 15);
    chk(sck == cpol, "R5", "sck idle level", int'(sck), int'(cpol));
    if (clr_hold) begin
      @(negedge clk);
      done_clr = 0;
    end else begin
      done_clr = 1;
      @(negedge clk);
      done_clr = 0;
    end
    chk(done_flag == 1'b0, "R6", "done cleared", int'(done_flag), 0);
    chk(irq == 1'b0, "R7", "irq drops on clear", int'(irq), 0);
    len = ((en - st) & 15) + 1;
    exp_rel = 1;
    chk(s_n == len, "R1", "transfer count", s_n, len);
    for (int n = 0; n < len; n++) begin
      idx = (st + n) & 15;
      if (n < len - 1 && !hold_of(idx, run)) exp_rel++;
      chk(idxlog[n] == 4'(idx), "R1", "entry order", int'(idxlog[n]), idx);
      chk(cap[n] == tx_of(idx, run), "R2", "mosi word", int'(cap[n]), int'(tx_of(idx, run)));
      chk(cslog[n] == ~mask_of(idx, run), "R3", "cs pattern", int'(cslog[n]),
          int'(~mask_of(idx, run)));
      @(negedge clk); rx_addr = 4'(idx);
      @(negedge clk);
      chk(rx_rdata == resp(n), "R2", "rx slot", int'(rx_rdata), int'(resp(n)));
    end
    chk(rel_cnt == exp_rel, "R4", "cs releases", rel_cnt, exp_rel);
    chk(gap_bad == 0, "R5", "sck half period", gap_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && done_flag == 0 && fault_flag == 0 && irq == 0, "R6",
        "reset flags", int'({busy, done_flag, fault_flag, irq}), 0);
    chk(cs_n == 4'hF, "R3", "reset cs", int'(cs_n), 15);
    chk(sck == 1'b0, "R5", "reset sck", int'(sck), 0);

    run_q(0, 15, 0, 1, 1, 0, 0);
    for (int m = 0; m < 4; m++)
      for (int h = 1; h < 4; h++) begin
        int st, ln;
        st = (m * 7 + h * 5) % 16;
        ln = ((m * 3 + h * 5) % 16) + 1;
        run_q(st, (st + ln - 1) % 16, m, h, bit'((m + h) % 2), 1 + m * 3 + h, 0);
      end
    run_q(12, 3, 2, 2, 1, 20, 0);   // R1 wrap past 15
    run_q(7, 7, 1, 1, 1, 21, 0);    // R1 single entry
    run_q(3, 6, 3, 1, 1, 22, 1);    // R6 set and clear in same cycle

    // R8 mode fault
    load_queue(30);
    @(negedge clk);
    cpol = 0; cpha = 0; clk_half = 8'd2; start_ptr = 0; end_ptr = 4'd15;
    s_n = 0; s_bi = 0;
    go = 1; @(negedge clk); go = 0;
    repeat (100) @(negedge clk);
    ss_in_n = 0; @(negedge clk); ss_in_n = 1;
    chk(busy == 1'b0, "R8", "busy after fault", int'(busy), 0);
    chk(fault_flag == 1'b1, "R8", "fault flag", int'(fault_flag), 1);
    chk(cs_n == 4'hF, "R8", "cs after fault", int'(cs_n), 15);
    chk(done_flag == 1'b0, "R8", "no done on fault", int'(done_flag), 0);
    go = 1; @(negedge clk); go = 0;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "start ignored under fault", int'(busy), 0);
    fault_clr = 1; @(negedge clk); fault_clr = 0;
    chk(fault_flag == 1'b0, "R8", "fault cleared", int'(fault_flag), 0);
    run_q(0, 4, 0, 1, 1, 23, 0);    // recovery after fault

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule